// File: doc/BRIEF.md
# JTAG Scan Chain Access Selector

This block connects the JTAG test data path to the scan structures of a large design. An instruction field chooses one of the manufacturing scan chains, a serial path through every manufacturing chain, or one of a separate set of shadow-register chains. The chosen structure is placed between TDI and TDO. Any code outside these ranges selects a one-bit bypass register. The TAP controller outside the block supplies the capture, shift and update decodes. The block turns those decodes into per-chain shift enables, routes scan-in and scan-out, and raises a snapshot strobe so the selected shadow chain can record live state while the functional clock keeps running.

The path is held in a small state machine. Its states are `M_BYPASS`, `M_SINGLE`, `M_SHADOW` and `M_CONCAT`. Reset enters `M_BYPASS`. On every cycle with the update decode high, the machine moves from whatever state it is in to the state that the select code decodes to, and it also loads the chain index. Without an update, it stays where it is. The code map is as follows:
- codes `0 .. N_CHAINS-1` go to `M_SINGLE` for that chain;
- codes `N_CHAINS .. N_CHAINS+N_SHADOW-1` go to `M_SHADOW` for chain `code-N_CHAINS`;
- code `N_CHAINS+N_SHADOW` goes to `M_CONCAT`;
- every higher code goes to `M_BYPASS`.

TDO is registered on the falling edge of TCK. Scan chains shift on the rising edge.

Top module: `jtag_chain_selector`

## Requirements
- R1: While `trst_n` is low, the path is `M_BYPASS`, every chain and shadow shift enable is low, `shadow_cap` is zero and `tdo` is 0.
- R2: The path and chain index change only on a rising TCK edge with `update_ir` high. A change of `sel_code` at any other time has no effect on the path.
- R3: With code k < N_CHAINS latched, during `shift_dr` only `chain_se[k]` is high, `chain_si[k]` carries TDI, and TDO shows the scan-out of chain k, least significant bit first.
- R4: A manufacturing or shadow chain outside the selected path never has its shift enable high, so its contents are held. No shift enable is high while `shift_dr` is low.
- R5: With code N_CHAINS+N_SHADOW latched, every manufacturing chain shifts together. Chain 0 takes TDI, the scan-out of chain n feeds the scan-in of chain n+1, and the last chain drives TDO. The whole path behaves as one first-in first-out serial path.
- R6: With shadow code N_CHAINS+j latched, `shadow_cap[j]` is high exactly in cycles with `capture_dr` high. The value captured in that cycle is then shifted out on TDO through chain j, and later changes of the live state do not alter it. In any other mode, `shadow_cap` stays zero.
- R7: Shadow capture and shift leave every manufacturing chain enable low, so the manufacturing chain contents survive a shadow access.
- R8: Under a bypass code, `capture_dr` clears the one-bit bypass register and each shift cycle loads TDI into it, so TDO shows TDI delayed by one shift cycle.
- R9: TDO changes only on a falling TCK edge. Just after a rising edge it still shows the bit it had before that edge, even when the selected scan-out has already changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_dr | input | 1 | TAP decode: capture data register state |
| shift_dr | input | 1 | TAP decode: shift data register state |
| update_ir | input | 1 | TAP decode: update instruction register state |
| sel_code | input | SEL_W | Chain-select field of the current instruction |
| tdi | input | 1 | Test data in |
| chain_so | input | N_CHAINS | Scan-out of each manufacturing chain |
| shadow_so | input | N_SHADOW | Scan-out of each shadow chain |
| chain_si | output | N_CHAINS | Scan-in of each manufacturing chain |
| chain_se | output | N_CHAINS | Shift enable of each manufacturing chain |
| shadow_si | output | N_SHADOW | Scan-in of each shadow chain |
| shadow_se | output | N_SHADOW | Shift enable of each shadow chain |
| shadow_cap | output | N_SHADOW | Snapshot strobe of each shadow chain |
| tdo | output | 1 | Test data out, registered on falling TCK |

## Verification
The bench builds the block with four manufacturing chains and two shadow chains, which gives a three-bit select field. At that size every code class can be reached: all four single-chain codes, both shadow codes, the concatenation code and one bypass code. The full concatenated path is only twelve bits long, so the bench can shift the whole path out and back in. It models three-bit manufacturing chains and four-bit shadow chains on the other side of the ports. With those models it shows that data pushed in comes back out in order, and that chain contents survive both single-chain and shadow accesses.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

    typedef enum logic [1:0] {
        M_BYPASS = 2'd0,
        M_SINGLE = 2'd1,
        M_SHADOW = 2'd2,
        M_CONCAT = 2'd3
    } path_mode_e;

endpackage

// File: rtl/jcs_mode_fsm.sv
module jcs_mode_fsm
    import jcs_pkg::*;
#(
    parameter int N_CHAINS = 32,
    parameter int N_SHADOW = 16,
    parameter int SEL_W    = 6,
    parameter int IDX_W    = 5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             update_ir,
    input  logic [SEL_W-1:0] sel_code,
    output path_mode_e       mode_q,
    output logic [IDX_W-1:0] idx_q
);

    localparam int SHD_BASE = N_CHAINS;
    localparam int CAT_CODE = N_CHAINS + N_SHADOW;

    path_mode_e       mode_d;
    logic [IDX_W-1:0] idx_d;
    logic [SEL_W-1:0] shd_off;

    assign shd_off = sel_code - SEL_W'(SHD_BASE);

    // Next-state decode: any state moves to the decoded class on update.
    always_comb begin
        mode_d = mode_q;
        idx_d  = idx_q;
        if (update_ir) begin
            if (int'(sel_code) < N_CHAINS) begin
                mode_d = M_SINGLE;
                idx_d  = sel_code[IDX_W-1:0];
            end else if (int'(sel_code) < CAT_CODE) begin
                mode_d = M_SHADOW;
                idx_d  = shd_off[IDX_W-1:0];
            end else if (int'(sel_code) == CAT_CODE) begin
                mode_d = M_CONCAT;
                idx_d  = '0;
            end else begin
                mode_d = M_BYPASS;
                idx_d  = '0;
            end
        end
    end

    // State register.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            mode_q <= M_BYPASS;
            idx_q  <= '0;
        end else begin
            mode_q <= mode_d;
            idx_q  <= idx_d;
        end
    end

    // R2: path frozen unless an update occurs
    p_hold_path_r2: assert property (@(posedge tck) disable iff (!trst_n)
        !update_ir |=> ($stable(mode_q) && $stable(idx_q)));

    // R5: the concatenation code reaches the concatenated state
    p_cat_decode_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (update_ir && int'(sel_code) == CAT_CODE) |=> (mode_q == M_CONCAT));

endmodule

// File: rtl/jcs_route.sv
module jcs_route
    import jcs_pkg::*;
#(
    parameter int N_CHAINS = 32,
    parameter int N_SHADOW = 16,
    parameter int IDX_W    = 5
) (
    input  logic                tck,
    input  logic                trst_n,
    input  path_mode_e          mode_q,
    input  logic [IDX_W-1:0]    idx_q,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                tdi,
    input  logic [N_CHAINS-1:0] chain_so,
    input  logic [N_SHADOW-1:0] shadow_so,
    output logic [N_CHAINS-1:0] chain_si,
    output logic [N_CHAINS-1:0] chain_se,
    output logic [N_SHADOW-1:0] shadow_si,
    output logic [N_SHADOW-1:0] shadow_se,
    output logic [N_SHADOW-1:0] shadow_cap,
    output logic                path_out
);

    logic [N_CHAINS-1:0] cat_si;
    logic [N_CHAINS-1:0] one_chain;
    logic [N_SHADOW-1:0] one_shadow;
    logic                chain_pick;
    logic                shadow_pick;

    // Serial ripple through the manufacturing chains for concatenation.
    assign cat_si[0] = tdi;
    generate
        for (genvar g = 1; g < N_CHAINS; g++) begin : g_cat
            assign cat_si[g] = chain_so[g-1];
        end
    endgenerate

    // One-hot chain decode and scan-out selection.
    always_comb begin
        one_chain  = '0;
        chain_pick = 1'b0;
        for (int i = 0; i < N_CHAINS; i++) begin
            if (idx_q == IDX_W'(i)) begin
                one_chain[i] = 1'b1;
                chain_pick   = chain_so[i];
            end
        end
    end

    always_comb begin
        one_shadow  = '0;
        shadow_pick = 1'b0;
        for (int j = 0; j < N_SHADOW; j++) begin
            if (idx_q == IDX_W'(j)) begin
                one_shadow[j] = 1'b1;
                shadow_pick   = shadow_so[j];
            end
        end
    end

    // Output process keyed on the path state.
    always_comb begin
        chain_si   = '0;
        chain_se   = '0;
        shadow_si  = '0;
        shadow_se  = '0;
        shadow_cap = '0;
        path_out   = 1'b0;
        unique case (mode_q)
            M_SINGLE: begin
                chain_si = one_chain & {N_CHAINS{tdi}};
                chain_se = one_chain & {N_CHAINS{shift_dr}};
                path_out = chain_pick;
            end
            M_SHADOW: begin
                shadow_si  = one_shadow & {N_SHADOW{tdi}};
                shadow_se  = one_shadow & {N_SHADOW{shift_dr}};
                shadow_cap = one_shadow & {N_SHADOW{capture_dr}};
                path_out   = shadow_pick;
            end
            M_CONCAT: begin
                chain_si = cat_si;
                chain_se = {N_CHAINS{shift_dr}};
                path_out = chain_so[N_CHAINS-1];
            end
            M_BYPASS: begin
                path_out = 1'b0;
            end
        endcase
    end

    // R3: at most one manufacturing chain moves in single mode
    p_single_onehot_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_q == M_SINGLE) |-> $onehot0(chain_se));

    // R4: no chain moves outside the shift state
    p_idle_quiet_r4: assert property (@(posedge tck) disable iff (!trst_n)
        !shift_dr |-> (chain_se == '0 && shadow_se == '0));

    // R6: snapshot strobe only in capture while a shadow chain is selected
    p_snap_gate_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (shadow_cap != '0) |-> (capture_dr && mode_q == M_SHADOW && $countones(shadow_cap) == 1));

    // R7: shadow access leaves manufacturing chains untouched
    p_shadow_quiet_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_q == M_SHADOW) |-> (chain_se == '0));

endmodule

// File: rtl/jcs_tdo_stage.sv
module jcs_tdo_stage
    import jcs_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       tdi,
    input  path_mode_e mode_q,
    input  logic       path_out,
    output logic       tdo
);

    logic byp_q;

    // One-bit bypass register.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (capture_dr) begin
            byp_q <= 1'b0;
        end else if (shift_dr) begin
            byp_q <= tdi;
        end
    end

    // Falling-edge output register.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo <= 1'b0;
        end else begin
            tdo <= (mode_q == M_BYPASS) ? byp_q : path_out;
        end
    end

    // R8: capture clears the bypass bit
    p_byp_clear_r8: assert property (@(posedge tck) disable iff (!trst_n)
        capture_dr |=> !byp_q);

    // R8: a shift without capture loads TDI
    p_byp_load_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !capture_dr) |=> (byp_q == $past(tdi)));

endmodule

// File: rtl/jtag_chain_selector.sv
module jtag_chain_selector
    import jcs_pkg::*;
#(
    parameter int N_CHAINS = 32,
    parameter int N_SHADOW = 16,
    parameter int SEL_W    = $clog2(N_CHAINS + N_SHADOW + 2)
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_ir,
    input  logic [SEL_W-1:0]    sel_code,
    input  logic                tdi,
    input  logic [N_CHAINS-1:0] chain_so,
    input  logic [N_SHADOW-1:0] shadow_so,
    output logic [N_CHAINS-1:0] chain_si,
    output logic [N_CHAINS-1:0] chain_se,
    output logic [N_SHADOW-1:0] shadow_si,
    output logic [N_SHADOW-1:0] shadow_se,
    output logic [N_SHADOW-1:0] shadow_cap,
    output logic                tdo
);

    localparam int MAX_N = (N_CHAINS > N_SHADOW) ? N_CHAINS : N_SHADOW;
    localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    path_mode_e       mode_q;
    logic [IDX_W-1:0] idx_q;
    logic             path_out;

    jcs_mode_fsm #(
        .N_CHAINS (N_CHAINS),
        .N_SHADOW (N_SHADOW),
        .SEL_W    (SEL_W),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .tck       (tck),
        .trst_n    (trst_n),
        .update_ir (update_ir),
        .sel_code  (sel_code),
        .mode_q    (mode_q),
        .idx_q     (idx_q)
    );

    jcs_route #(
        .N_CHAINS (N_CHAINS),
        .N_SHADOW (N_SHADOW),
        .IDX_W    (IDX_W)
    ) u_route (
        .tck        (tck),
        .trst_n     (trst_n),
        .mode_q     (mode_q),
        .idx_q      (idx_q),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .chain_so   (chain_so),
        .shadow_so  (shadow_so),
        .chain_si   (chain_si),
        .chain_se   (chain_se),
        .shadow_si  (shadow_si),
        .shadow_se  (shadow_se),
        .shadow_cap (shadow_cap),
        .path_out   (path_out)
    );

    jcs_tdo_stage u_tdo (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .mode_q     (mode_q),
        .path_out   (path_out),
        .tdo        (tdo)
    );

endmodule

// File: tb/jtag_chain_selector_bench.sv
module jtag_chain_selector_bench;

    localparam int NCH = 4;
    localparam int NSH = 2;
    localparam int SW  = $clog2(NCH + NSH + 2);
    localparam int ML  = 3;
    localparam int SL  = 4;

    logic           tck = 1'b0;
    logic           trst_n = 1'b0;
    logic           capture_dr = 1'b0;
    logic           shift_dr = 1'b0;
    logic           update_ir = 1'b0;
    logic [SW-1:0]  sel_code = '0;
    logic           tdi = 1'b0;
    logic [NCH-1:0] chain_so;
    logic [NSH-1:0] shadow_so;
    logic [NCH-1:0] chain_si, chain_se;
    logic [NSH-1:0] shadow_si, shadow_se, shadow_cap;
    logic           tdo;

    int n_cmp = 0;
    int n_bad = 0;
    logic mon_en = 1'b0;

    typedef struct {
        logic  bitv;
        string tag;
    } exp_t;
    exp_t sb[$];

    logic [ML-1:0] mreg [NCH];
    logic [SL-1:0] sreg [NSH];
    logic [SL-1:0] live [NSH];

    always #5 tck = ~tck;

    jtag_chain_selector #(.N_CHAINS(NCH), .N_SHADOW(NSH)) u_jtag_chain_selector (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_ir(update_ir), .sel_code(sel_code), .tdi(tdi),
        .chain_so(chain_so), .shadow_so(shadow_so), .chain_si(chain_si),
        .chain_se(chain_se), .shadow_si(shadow_si), .shadow_se(shadow_se),
        .shadow_cap(shadow_cap), .tdo(tdo)
    );

    // Scan chain models on the far side of the ports.
    always @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            mreg[0] <= 3'b101;
            mreg[1] <= 3'b011;
            mreg[2] <= 3'b110;
            mreg[3] <= 3'b001;
            for (int j = 0; j < NSH; j++) sreg[j] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++)
                if (chain_se[i]) mreg[i] <= {chain_si[i], mreg[i][ML-1:1]};
            for (int j = 0; j < NSH; j++) begin
                if (shadow_cap[j]) sreg[j] <= live[j];
                else if (shadow_se[j]) sreg[j] <= {shadow_si[j], sreg[j][SL-1:1]};
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) chain_so[i] = mreg[i][0];
        for (int j = 0; j < NSH; j++) shadow_so[j] = sreg[j][0];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard once per shift cycle after the falling edge.
    always @(negedge tck) begin
        #2;
        if (mon_en) begin
            if (sb.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL scoreboard empty actual=%0b expected=none", tdo);
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk(it.tag, {31'd0, tdo}, {31'd0, it.bitv});
            end
        end
    end

    task automatic pulse_update(input logic [SW-1:0] code);
        sel_code  = code;
        update_ir = 1'b1;
        @(posedge tck); #1;
        update_ir = 1'b0;
    endtask

    task automatic capture_check(input logic [NSH-1:0] exp_cap, input string tag);
        capture_dr = 1'b1;
        #1;
        chk(tag, {30'd0, shadow_cap}, {30'd0, exp_cap});
        chk({tag, " chain_se"}, {28'd0, chain_se}, 32'd0);
        @(posedge tck); #1;
        capture_dr = 1'b0;
    endtask

    // Driver: pushes expected TDO bits and drives TDI for n shift cycles.
    task automatic shift_seq(input int n, input logic [15:0] tdi_bits,
                             input logic [15:0] exp_bits, input logic [NCH-1:0] exp_cse,
                             input logic [NSH-1:0] exp_sse, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            it.bitv = exp_bits[i];
            it.tag  = tag;
            sb.push_back(it);
            shift_dr = 1'b1;
            tdi      = tdi_bits[i];
            mon_en   = 1'b1;
            if (i == 0) begin
                #1;
                chk({tag, " R4 chain_se"}, {28'd0, chain_se}, {28'd0, exp_cse});
                chk({tag, " R4 shadow_se"}, {30'd0, shadow_se}, {30'd0, exp_sse});
            end
            @(posedge tck); #1;
        end
        shift_dr = 1'b0;
        mon_en   = 1'b0;
        chk({tag, " scoreboard drained"}, sb.size(), 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        live[0] = '0;
        live[1] = '0;
        repeat (3) @(posedge tck);
        #1;
        // R1 reset state
        chk("R1 tdo", {31'd0, tdo}, 32'd0);
        chk("R1 chain_se", {28'd0, chain_se}, 32'd0);
        chk("R1 shadow_se", {30'd0, shadow_se}, 32'd0);
        chk("R1 shadow_cap", {30'd0, shadow_cap}, 32'd0);
        trst_n = 1'b1;
        @(posedge tck); #1;

        // R8 bypass after reset: captured 0 then TDI delayed by one
        capture_dr = 1'b1;
        @(posedge tck); #1;
        capture_dr = 1'b0;
        shift_seq(4, 16'b1101, 16'b1010, '0, '0, "R8 bypass after reset");
        // R8 unused code 7: bypass bit still holds 1 from the last shift
        pulse_update(3'd7);
        shift_seq(3, 16'b110, 16'b101, '0, '0, "R8 unused code");

        // R3 single chain 2, with R9 falling-edge check
        pulse_update(3'd2);
        shift_dr = 1'b1;
        tdi      = 1'b1;
        #1;
        chk("R3 chain_se one-hot", {28'd0, chain_se}, 32'h4);
        chk("R3 chain_si carries tdi", {28'd0, chain_si}, 32'h4);
        @(negedge tck); #2;
        chk("R3 first bit", {31'd0, tdo}, 32'd0);
        @(posedge tck); #1;
        chk("R9 scan-out moved", {31'd0, chain_so[2]}, 32'd1);
        chk("R9 tdo held after rising edge", {31'd0, tdo}, 32'd0);
        shift_seq(2, 16'b11, 16'b11, 4'b0100, '0, "R3 single chain rest");
        shift_seq(3, 16'b000, 16'b111, 4'b0100, '0, "R3 single chain readback");

        // R5 concatenation, R2 sel_code change without update ignored
        pulse_update(3'd6);
        sel_code = 3'd0;
        shift_seq(12, 16'h05A3, 16'h0AC1, 4'hF, '0, "R5 R2 concat order");
        shift_seq(12, 16'h03C6, 16'h05A3, 4'hF, '0, "R5 concat fifo");

        // R6 shadow 0 snapshot, R7 manufacturing chains idle
        pulse_update(3'd4);
        live[0] = 4'hA;
        capture_check(2'b01, "R6 R7 shadow0 capture");
        live[0] = 4'h5;
        shift_seq(4, 16'h0, 16'hA, '0, 2'b01, "R6 R7 shadow0 snapshot");

        // R6 shadow 1 snapshot
        pulse_update(3'd5);
        live[1] = 4'h3;
        capture_check(2'b10, "R6 shadow1 capture");
        live[1] = 4'hC;
        shift_seq(4, 16'h0, 16'h3, '0, 2'b10, "R6 shadow1 snapshot");

        // R6 no strobe outside shadow mode; R7 chains survived shadow access
        pulse_update(3'd6);
        capture_check(2'b00, "R6 no strobe in concat");
        shift_seq(12, 16'h0, 16'h03C6, 4'hF, '0, "R7 chains held across shadow access");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule